// File: doc/BRIEF.md
# Swizzled Relative-Addressed Operand Fetch

This block is the operand-read and write-mask stage of a four-component vector shader unit. It holds model register arrays for shader inputs, temporaries, float uniforms and output registers. Each of the three source operands names a register class and an index. The block reads the vector for each source and reorders its four components through a per-component selector. It can also flip the sign of every component. The result comes out combinationally, in the same cycle.

Float-uniform sources can be addressed relative to one of three address values: two address registers and the loop counter. An offset that does not fit a signed byte counts as zero. The effective index wraps at 128. Any uniform index at or above the end of the uniform array reads as a vector of 1.0 constants. The instruction form decides which source takes the offset. On the write side, a destination code is decoded into an output register, a temporary register, or nothing. A four-bit mask then picks which components are written on the next clock edge. A preload port fills the input and uniform arrays, and an observation port reads back the output registers.

Top module: `opf_operand_fetch`

## Requirements
- R1: After reset every register array holds zero, so each class reads as all-zero components and the observation port returns zero.
- R2: A source class code of 0 reads input register idx[3:0], 1 reads temporary register idx[3:0], 2 reads a float uniform, and 3 reads four zero components.
- R3: Output component i (bits [24i+23:24i], i = 0 being x) is source component s[2i+1:2i] of the swizzle byte s, where 0 = x, 1 = y, 2 = z and 3 = w.
- R4: When a source's negate bit is set, bit 23 of all four components is inverted after the swizzle.
- R5: Address-select code 0 applies no offset. Codes 1, 2 and 3 take the offset from addr_a0, addr_a1 and addr_loop. The offset changes the index only when the class is float uniform.
- R6: The form code picks the offset target. Form 0 (normal) targets source 1, form 1 (inverted) targets source 2, form 2 (multiply-add) targets source 2, and form 3 (inverted multiply-add) targets source 3. No other source is ever offset.
- R7: An address value below -128 or above 127 gives an offset of zero.
- R8: The effective uniform index is (index + offset) modulo 128.
- R9: A uniform read whose effective index is 96 or above returns 0x3F0000 in all four components.
- R10: On wr_en, a destination code below 0x10 writes output register code[3:0]. A code from 0x10 to 0x1F writes temporary register code[3:0]. A code of 0x20 or above changes nothing. The write is visible from the clock edge that samples it.
- R11: Only the components whose bit i is set in wr_mask are written. The other components keep their value.
- R12: The preload port writes a whole vector on the clock edge: ld_sel 0 writes input ld_idx, and ld_sel 1 writes uniform ld_idx. An input index of 16 or above, or a uniform index of 96 or above, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| form | input | 2 | Instruction form: 0 normal, 1 inverted, 2 multiply-add, 3 inverted multiply-add |
| asel | input | 2 | Address-select code |
| addr_a0 | input | 16 | First address register, signed |
| addr_a1 | input | 16 | Second address register, signed |
| addr_loop | input | 16 | Loop counter register, signed |
| s1_cls | input | 2 | Source 1 register class |
| s1_idx | input | 7 | Source 1 index |
| s1_swz | input | 8 | Source 1 component selectors |
| s1_neg | input | 1 | Source 1 negate |
| s2_cls | input | 2 | Source 2 register class |
| s2_idx | input | 7 | Source 2 index |
| s2_swz | input | 8 | Source 2 component selectors |
| s2_neg | input | 1 | Source 2 negate |
| s3_cls | input | 2 | Source 3 register class |
| s3_idx | input | 7 | Source 3 index |
| s3_swz | input | 8 | Source 3 component selectors |
| s3_neg | input | 1 | Source 3 negate |
| op1 | output | 96 | Source 1 operand, four 24-bit components |
| op2 | output | 96 | Source 2 operand |
| op3 | output | 96 | Source 3 operand |
| wr_en | input | 1 | Result write strobe |
| wr_dest | input | 7 | Destination code |
| wr_mask | input | 4 | Component write enables |
| wr_data | input | 96 | Result vector |
| ld_en | input | 1 | Preload strobe |
| ld_sel | input | 1 | Preload target: 0 input, 1 uniform |
| ld_idx | input | 7 | Preload index |
| ld_data | input | 96 | Preload vector |
| obs_idx | input | 4 | Output register to observe |
| obs_vec | output | 96 | Observed output register |

## Verification
The operand outputs and obs_vec have no register between them and the inputs. The bench changes the source fields on a falling edge and compares op1..op3 one nanosecond later, well before the next rising edge. Writes and preloads land on the rising edge that samples them. The bench therefore reads the target once before that edge, expecting the old value, and once at the following falling edge, expecting the new one. This shows that the storage path takes exactly one cycle.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int COMP_W = 24;
  localparam int NCOMP  = 4;
  localparam int VEC_W  = COMP_W * NCOMP;
  localparam int IDX_W  = 7;
  localparam int OFF_W  = 8;
  localparam int ADDR_W = 16;
  localparam int SWZ_W  = 2 * NCOMP;
  localparam logic [COMP_W-1:0] ONE_CONST = 24'h3F0000;
  localparam logic [VEC_W-1:0]  ONES_VEC  = {NCOMP{ONE_CONST}};

  typedef enum logic [1:0] {CLS_IN = 2'd0, CLS_TMP = 2'd1, CLS_UNI = 2'd2, CLS_NONE = 2'd3} src_cls_e;
  typedef enum logic [1:0] {FORM_STD = 2'd0, FORM_INV = 2'd1, FORM_MAD = 2'd2, FORM_MADINV = 2'd3} form_e;

  // Offsets that do not fit a signed byte collapse to zero.
  function automatic logic [OFF_W-1:0] clamp_off(input logic signed [ADDR_W-1:0] a);
    if (a > 16'sd127 || a < -16'sd128) return '0;
    return a[OFF_W-1:0];
  endfunction

  // Index plus two's-complement offset, modulo 2**IDX_W.
  function automatic logic [IDX_W-1:0] wrap_idx(input logic [IDX_W-1:0] idx,
                                                input logic [OFF_W-1:0] off);
    return IDX_W'({1'b0, idx} + off);
  endfunction

  function automatic logic [VEC_W-1:0] swz_vec(input logic [VEC_W-1:0] v,
                                               input logic [SWZ_W-1:0] s);
    logic [VEC_W-1:0] r;
    for (int i = 0; i < NCOMP; i++)
      r[i*COMP_W +: COMP_W] = v[int'(s[2*i +: 2])*COMP_W +: COMP_W];
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] neg_vec(input logic [VEC_W-1:0] v, input logic neg);
    logic [VEC_W-1:0] r;
    r = v;
    for (int i = 0; i < NCOMP; i++)
      r[i*COMP_W + COMP_W - 1] = v[i*COMP_W + COMP_W - 1] ^ neg;
    return r;
  endfunction
endpackage

// File: rtl/opf_offset_sel.sv
module opf_offset_sel
  import opf_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [1:0]               form_i,
  input  logic [1:0]               asel_i,
  input  logic signed [ADDR_W-1:0] a0_i,
  input  logic signed [ADDR_W-1:0] a1_i,
  input  logic signed [ADDR_W-1:0] aloop_i,
  output logic [OFF_W-1:0]         off_o,
  output logic [NSRC-1:0]          apply_o
);
  logic signed [ADDR_W-1:0] picked;
  logic [NSRC-1:0]          target;

  always_comb begin
    unique case (asel_i)
      2'd1:    picked = a0_i;
      2'd2:    picked = a1_i;
      2'd3:    picked = aloop_i;
      default: picked = '0;
    endcase
  end

  always_comb begin
    target = '0;
    unique case (form_e'(form_i))
      FORM_STD:    target[0] = 1'b1;
      FORM_INV:    target[1] = 1'b1;
      FORM_MAD:    target[1] = 1'b1;
      FORM_MADINV: target[2] = 1'b1;
      default:     target = '0;
    endcase
  end

  assign off_o   = clamp_off(picked);
  assign apply_o = (asel_i != 2'd0) ? target : '0;
endmodule

// File: rtl/opf_regfile.sv
module opf_regfile
  import opf_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int N_OUT  = 16,
  parameter int N_UNIF = 96,
  parameter int NRD    = 3,
  localparam int IN_AW  = $clog2(N_IN),
  localparam int TMP_AW = $clog2(N_TMP),
  localparam int OUT_AW = $clog2(N_OUT),
  localparam int TMP_BASE = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][1:0]        rd_cls_i,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx_i,
  output logic [NRD-1:0][VEC_W-1:0]  rd_vec_o,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_dest_i,
  input  logic [NCOMP-1:0]           wr_mask_i,
  input  logic [VEC_W-1:0]           wr_data_i,
  input  logic                       ld_en_i,
  input  logic                       ld_sel_i,
  input  logic [IDX_W-1:0]           ld_idx_i,
  input  logic [VEC_W-1:0]           ld_data_i,
  input  logic [OUT_AW-1:0]          obs_idx_i,
  output logic [VEC_W-1:0]           obs_vec_o,
  output logic                       wr_to_out_o,
  output logic                       wr_to_tmp_o,
  output logic                       wr_discard_o
);
  logic [VEC_W-1:0] in_rf  [N_IN];
  logic [VEC_W-1:0] tmp_rf [N_TMP];
  logic [VEC_W-1:0] out_rf [N_OUT];
  logic [VEC_W-1:0] uni_rf [N_UNIF];

  assign wr_to_out_o  = wr_en_i && (wr_dest_i < IDX_W'(N_OUT));
  assign wr_to_tmp_o  = wr_en_i && (wr_dest_i >= IDX_W'(TMP_BASE)) &&
                        (wr_dest_i < IDX_W'(TMP_BASE + N_TMP));
  assign wr_discard_o = wr_en_i && !wr_to_out_o && !wr_to_tmp_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_OUT; i++) out_rf[i] <= '0;
    end else if (wr_to_out_o) begin
      for (int c = 0; c < NCOMP; c++)
        if (wr_mask_i[c])
          out_rf[wr_dest_i[OUT_AW-1:0]][c*COMP_W +: COMP_W] <= wr_data_i[c*COMP_W +: COMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TMP; i++) tmp_rf[i] <= '0;
    end else if (wr_to_tmp_o) begin
      for (int c = 0; c < NCOMP; c++)
        if (wr_mask_i[c])
          tmp_rf[wr_dest_i[TMP_AW-1:0]][c*COMP_W +: COMP_W] <= wr_data_i[c*COMP_W +: COMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) in_rf[i] <= '0;
    end else if (ld_en_i && !ld_sel_i && (ld_idx_i < IDX_W'(N_IN))) begin
      in_rf[ld_idx_i[IN_AW-1:0]] <= ld_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_UNIF; i++) uni_rf[i] <= '0;
    end else if (ld_en_i && ld_sel_i && (ld_idx_i < IDX_W'(N_UNIF))) begin
      uni_rf[ld_idx_i] <= ld_data_i;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [VEC_W-1:0] v;
    always_comb begin
      unique case (src_cls_e'(rd_cls_i[k]))
        CLS_IN:  v = in_rf[rd_idx_i[k][IN_AW-1:0]];
        CLS_TMP: v = tmp_rf[rd_idx_i[k][TMP_AW-1:0]];
        CLS_UNI: v = (rd_idx_i[k] >= IDX_W'(N_UNIF)) ? ONES_VEC : uni_rf[rd_idx_i[k]];
        default: v = '0;
      endcase
    end
    assign rd_vec_o[k] = v;
  end

  assign obs_vec_o = out_rf[obs_idx_i];
endmodule

// File: rtl/opf_swz_neg.sv
module opf_swz_neg
  import opf_pkg::*;
(
  input  logic [VEC_W-1:0] raw_i,
  input  logic [SWZ_W-1:0] swz_i,
  input  logic             neg_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] picked;
  assign picked = swz_vec(raw_i, swz_i);
  assign vec_o  = neg_vec(picked, neg_i);
endmodule

// File: rtl/opf_operand_fetch.sv
module opf_operand_fetch
  import opf_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int N_OUT  = 16,
  parameter int N_UNIF = 96,
  localparam int OUT_AW = $clog2(N_OUT),
  localparam int NSRC   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               form,
  input  logic [1:0]               asel,
  input  logic signed [ADDR_W-1:0] addr_a0,
  input  logic signed [ADDR_W-1:0] addr_a1,
  input  logic signed [ADDR_W-1:0] addr_loop,
  input  logic [1:0]               s1_cls,
  input  logic [IDX_W-1:0]         s1_idx,
  input  logic [SWZ_W-1:0]         s1_swz,
  input  logic                     s1_neg,
  input  logic [1:0]               s2_cls,
  input  logic [IDX_W-1:0]         s2_idx,
  input  logic [SWZ_W-1:0]         s2_swz,
  input  logic                     s2_neg,
  input  logic [1:0]               s3_cls,
  input  logic [IDX_W-1:0]         s3_idx,
  input  logic [SWZ_W-1:0]         s3_swz,
  input  logic                     s3_neg,
  output logic [VEC_W-1:0]         op1,
  output logic [VEC_W-1:0]         op2,
  output logic [VEC_W-1:0]         op3,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_dest,
  input  logic [NCOMP-1:0]         wr_mask,
  input  logic [VEC_W-1:0]         wr_data,
  input  logic                     ld_en,
  input  logic                     ld_sel,
  input  logic [IDX_W-1:0]         ld_idx,
  input  logic [VEC_W-1:0]         ld_data,
  input  logic [OUT_AW-1:0]        obs_idx,
  output logic [VEC_W-1:0]         obs_vec
);
  logic [OFF_W-1:0]             off_val;
  logic [NSRC-1:0]              apply_vec;
  logic [NSRC-1:0][1:0]         cls_v;
  logic [NSRC-1:0][IDX_W-1:0]   idx_v;
  logic [NSRC-1:0][IDX_W-1:0]   eff_idx_v;
  logic [NSRC-1:0][SWZ_W-1:0]   swz_v;
  logic [NSRC-1:0]              neg_v;
  logic [NSRC-1:0][VEC_W-1:0]   raw_v;
  logic [NSRC-1:0][VEC_W-1:0]   opv;
  logic                         wr_to_out;
  logic                         wr_to_tmp;
  logic                         wr_discard;

  assign cls_v = {s3_cls, s2_cls, s1_cls};
  assign idx_v = {s3_idx, s2_idx, s1_idx};
  assign swz_v = {s3_swz, s2_swz, s1_swz};
  assign neg_v = {s3_neg, s2_neg, s1_neg};

  opf_offset_sel #(.NSRC(NSRC)) u_off (
    .form_i  (form),
    .asel_i  (asel),
    .a0_i    (addr_a0),
    .a1_i    (addr_a1),
    .aloop_i (addr_loop),
    .off_o   (off_val),
    .apply_o (apply_vec)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign eff_idx_v[k] = (apply_vec[k] && (cls_v[k] == CLS_UNI)) ?
                          wrap_idx(idx_v[k], off_val) : idx_v[k];
    opf_swz_neg u_sn (
      .raw_i (raw_v[k]),
      .swz_i (swz_v[k]),
      .neg_i (neg_v[k]),
      .vec_o (opv[k])
    );
  end

  opf_regfile #(
    .N_IN(N_IN), .N_TMP(N_TMP), .N_OUT(N_OUT), .N_UNIF(N_UNIF), .NRD(NSRC)
  ) u_rf (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_cls_i     (cls_v),
    .rd_idx_i     (eff_idx_v),
    .rd_vec_o     (raw_v),
    .wr_en_i      (wr_en),
    .wr_dest_i    (wr_dest),
    .wr_mask_i    (wr_mask),
    .wr_data_i    (wr_data),
    .ld_en_i      (ld_en),
    .ld_sel_i     (ld_sel),
    .ld_idx_i     (ld_idx),
    .ld_data_i    (ld_data),
    .obs_idx_i    (obs_idx),
    .obs_vec_o    (obs_vec),
    .wr_to_out_o  (wr_to_out),
    .wr_to_tmp_o  (wr_to_tmp),
    .wr_discard_o (wr_discard)
  );

  assign op1 = opv[0];
  assign op2 = opv[1];
  assign op3 = opv[2];
endmodule

// File: rtl/opf_operand_fetch_chk.sv
module opf_operand_fetch_chk
  import opf_pkg::*;
#(
  parameter int N_UNIF = 96,
  parameter int NSRC   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               asel,
  input logic signed [ADDR_W-1:0] addr_a0,
  input logic signed [ADDR_W-1:0] addr_a1,
  input logic signed [ADDR_W-1:0] addr_loop,
  input logic [OFF_W-1:0]         off_val,
  input logic [NSRC-1:0]          apply_vec,
  input logic [NSRC-1:0][1:0]     cls_v,
  input logic [NSRC-1:0][IDX_W-1:0] eff_idx_v,
  input logic [NSRC-1:0][VEC_W-1:0] raw_v,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_dest,
  input logic                     wr_to_out,
  input logic                     wr_to_tmp,
  input logic                     wr_discard
);
  logic signed [ADDR_W-1:0] chosen;
  assign chosen = (asel == 2'd1) ? addr_a0 : (asel == 2'd2) ? addr_a1 : addr_loop;

  // R7: out-of-byte-range address values give no offset
  a_r7_wide_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (asel != 2'd0 && (chosen > 16'sd127 || chosen < -16'sd128)) |-> off_val == '0);

  // R5: code 0 leaves every source unoffset
  a_r5_code0_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
    asel == 2'd0 |-> apply_vec == '0);

  // R6: at most one source takes the offset
  a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(apply_vec));

  // R10: decode classes are exclusive and high codes are dropped
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_to_out, wr_to_tmp, wr_discard}));
  a_r10_high_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dest >= 7'h20) |-> (wr_discard && !wr_to_out && !wr_to_tmp));

  for (genvar k = 0; k < NSRC; k++) begin : g_k
    // R9: high uniform indices read as constant ones
    a_r9_high_uniform_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_v[k] == CLS_UNI && eff_idx_v[k] >= IDX_W'(N_UNIF)) |-> raw_v[k] == ONES_VEC);
    // R2: class 3 reads zero
    a_r2_none_class_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cls_v[k] == CLS_NONE |-> raw_v[k] == '0);
  end
endmodule

bind opf_operand_fetch opf_operand_fetch_chk #(.N_UNIF(N_UNIF), .NSRC(NSRC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .asel       (asel),
  .addr_a0    (addr_a0),
  .addr_a1    (addr_a1),
  .addr_loop  (addr_loop),
  .off_val    (off_val),
  .apply_vec  (apply_vec),
  .cls_v      (cls_v),
  .eff_idx_v  (eff_idx_v),
  .raw_v      (raw_v),
  .wr_en      (wr_en),
  .wr_dest    (wr_dest),
  .wr_to_out  (wr_to_out),
  .wr_to_tmp  (wr_to_tmp),
  .wr_discard (wr_discard)
);

// File: tb/opf_operand_fetch_tb_top.sv
`timescale 1ns/100ps
module opf_operand_fetch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] form = '0, asel = '0;
  logic signed [15:0] addr_a0 = '0, addr_a1 = '0, addr_loop = '0;
  logic [1:0] s1_cls = '0, s2_cls = '0, s3_cls = '0;
  logic [6:0] s1_idx = '0, s2_idx = '0, s3_idx = '0;
  logic [7:0] s1_swz = 8'hE4, s2_swz = 8'hE4, s3_swz = 8'hE4;
  logic s1_neg = 1'b0, s2_neg = 1'b0, s3_neg = 1'b0;
  logic [95:0] op1, op2, op3, obs_vec;
  logic wr_en = 1'b0;
  logic [6:0] wr_dest = '0;
  logic [3:0] wr_mask = '0;
  logic [95:0] wr_data = '0;
  logic ld_en = 1'b0, ld_sel = 1'b0;
  logic [6:0] ld_idx = '0;
  logic [95:0] ld_data = '0;
  logic [3:0] obs_idx = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opf_operand_fetch dut_i (.*);

  function automatic logic [23:0] cval(int cls, int idx, int c);
    return 24'((cls << 20) | (idx << 8) | c);
  endfunction

  function automatic logic [95:0] allv(int cls, int idx);
    logic [95:0] r;
    for (int c = 0; c < 4; c++) r[c*24 +: 24] = cval(cls, idx, c);
    return r;
  endfunction

  // Independent model of one source operand.
  function automatic logic [95:0] expect_src(int fm, int as, int aval, int k,
                                             int cls, int idx, int swz, bit ng);
    int tgt, off, e, sel;
    logic [23:0] comp;
    logic [95:0] r;
    tgt = (fm == 0) ? 1 : (fm == 3) ? 3 : 2;
    off = (as == 0 || aval < -128 || aval > 127) ? 0 : aval;
    e = idx;
    if (cls == 2 && k == tgt) e = (idx + off) & 127;
    for (int i = 0; i < 4; i++) begin
      sel = (swz >> (2 * i)) & 3;
      case (cls)
        0: comp = cval(0, idx % 16, sel);
        1: comp = cval(1, idx % 16, sel);
        2: comp = (e >= 96) ? 24'h3F0000 : cval(2, e, sel);
        default: comp = 24'h0;
      endcase
      if (ng) comp = comp ^ 24'h800000;
      r[i*24 +: 24] = comp;
    end
    return r;
  endfunction

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_src(int cls, int idx, int swz, bit ng);
    s1_cls = 2'(cls); s2_cls = 2'(cls); s3_cls = 2'(cls);
    s1_idx = 7'(idx); s2_idx = 7'(idx); s3_idx = 7'(idx);
    s1_swz = 8'(swz); s2_swz = 8'(swz); s3_swz = 8'(swz);
    s1_neg = ng; s2_neg = ng; s3_neg = ng;
  endtask

  task automatic do_write(int dest, int mask, logic [95:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_dest = 7'(dest); wr_mask = 4'(mask); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_load(bit sel, int idx, logic [95:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_idx = 7'(idx); ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // {form, asel, aval, cls, idx, swz, neg}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 2'd0, 16'h0005, 2'd2, 7'd10, 8'hE4, 1'b0},
    {2'd0, 2'd1, 16'h0005, 2'd2, 7'd10, 8'h1B, 1'b0},
    {2'd1, 2'd2, 16'hFFFD, 2'd2, 7'd10, 8'hE4, 1'b1},
    {2'd2, 2'd3, 16'h0014, 2'd2, 7'd80, 8'h00, 1'b0},
    {2'd3, 2'd1, 16'h007F, 2'd2, 7'd5,  8'hE4, 1'b0},
    {2'd0, 2'd1, 16'h0080, 2'd2, 7'd30, 8'hE4, 1'b0},
    {2'd0, 2'd2, 16'hFF7F, 2'd2, 7'd30, 8'h93, 1'b0},
    {2'd0, 2'd1, 16'hFFEC, 2'd2, 7'd10, 8'hE4, 1'b0},
    {2'd0, 2'd1, 16'h0007, 2'd0, 7'd3,  8'h39, 1'b0},
    {2'd1, 2'd1, 16'h0007, 2'd1, 7'd4,  8'h55, 1'b1},
    {2'd0, 2'd0, 16'h0000, 2'd3, 7'd2,  8'hE4, 1'b0},
    {2'd0, 2'd0, 16'h0000, 2'd3, 7'd2,  8'hE4, 1'b1},
    {2'd0, 2'd0, 16'h0000, 2'd2, 7'd100, 8'hE4, 1'b1},
    {2'd2, 2'd1, 16'h0004, 2'd2, 7'd2,  8'h9C, 1'b0},
    {2'd3, 2'd3, 16'hFFFE, 2'd2, 7'd1,  8'hE4, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [95:0] d, e;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every array
    set_src(0, 0, 8'hE4, 1'b0); #1 check("R1 input", op1, '0);
    set_src(1, 3, 8'hE4, 1'b0); #1 check("R1 temp", op2, '0);
    set_src(2, 10, 8'hE4, 1'b0); #1 check("R1 uniform", op3, '0);
    obs_idx = 4'd5; #1 check("R1 output", obs_vec, '0);

    // R12: preload inputs and uniforms; one-cycle landing checked on input 0
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 1'b0; ld_idx = 7'd0; ld_data = allv(0, 0);
    set_src(0, 0, 8'hE4, 1'b0);
    #1 check("R12 before edge", op1, '0);
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
    #1 check("R12 after edge", op1, allv(0, 0));
    for (int i = 1; i < 16; i++) do_load(1'b0, i, allv(0, i));
    for (int i = 0; i < 96; i++) do_load(1'b1, i, allv(2, i));
    for (int i = 0; i < 16; i++) do_write(16 + i, 4'hF, allv(1, i));

    do_load(1'b0, 20, {4{24'hABCDEF}});
    set_src(0, 4, 8'hE4, 1'b0); #1 check("R12 input idx 20 ignored", op1, allv(0, 4));

    // R2 R3 R4 R5 R6 R7 R8 R9: table walk
    for (int v = 0; v < NV; v++) begin
      int fm, as, av, cl, ix, sw;
      bit ng;
      fm = int'(VEC[v][37:36]); as = int'(VEC[v][35:34]);
      av = int'($signed(VEC[v][33:18]));
      cl = int'(VEC[v][17:16]); ix = int'(VEC[v][15:9]);
      sw = int'(VEC[v][8:1]); ng = VEC[v][0];
      @(negedge clk);
      form = 2'(fm); asel = 2'(as);
      addr_a0   = (as == 1 || as == 0) ? 16'(av) : 16'sd2;
      addr_a1   = (as == 2 || as == 0) ? 16'(av) : 16'sd2;
      addr_loop = (as == 3 || as == 0) ? 16'(av) : 16'sd2;
      set_src(cl, ix, sw, ng);
      #1;
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 vec%0d src1", v), op1, expect_src(fm, as, av, 1, cl, ix, sw, ng));
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 vec%0d src2", v), op2, expect_src(fm, as, av, 2, cl, ix, sw, ng));
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 vec%0d src3", v), op3, expect_src(fm, as, av, 3, cl, ix, sw, ng));
    end
    asel = 2'd0;

    // R11: masked temporary write, components x and z only
    d = {4{24'h123456}};
    do_write(8'h13, 4'b0101, d);
    e = allv(1, 3); e[23:0] = 24'h123456; e[71:48] = 24'h123456;
    set_src(1, 3, 8'hE4, 1'b0); #1 check("R11 temp mask 0101", op1, e);

    // R10 R11: output write, y and w only, landing one edge later
    @(negedge clk);
    wr_en = 1'b1; wr_dest = 7'h05; wr_mask = 4'b1010; wr_data = {4{24'h00ABCD}};
    obs_idx = 4'd5;
    #1 check("R10 output before edge", obs_vec, '0);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    e = '0; e[47:24] = 24'h00ABCD; e[95:72] = 24'h00ABCD;
    #1 check("R10 R11 output mask 1010", obs_vec, e);

    // R10: codes 0x25 and 0x7F are dropped
    do_write(8'h25, 4'hF, {4{24'h777777}});
    do_write(8'h7F, 4'hF, {4{24'h777777}});
    set_src(1, 5, 8'hE4, 1'b0); #1 check("R10 high code temp untouched", op1, allv(1, 5));
    obs_idx = 4'd5; #1 check("R10 high code output untouched", obs_vec, e);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule